// File: doc/BRIEF.md
# Gated Multi-Channel Pulse Scaler

This block counts digital pulses on ten independent inputs over a shared, programmable integration window. Each input is brought into the system clock domain and edge-detected, so a pulse adds one count however long it stays high. While the host holds `run` high, a period timer marks the end of each window. At that edge every channel copies its count into a holding register, and its live count restarts in the same cycle, so counting has no dead time. A pulse detected on that boundary cycle belongs to the new window.

Held values are quantised to whole steps of five. The part of a count below one step stays in the live counter and carries into the next window, so no pulse is ever lost. When the snapshot is taken, an interrupt goes to the host and stays up until the host acknowledges it. The host then clocks all held values out of a serial port framed by a chip-select. The next window is counted while the readout is in progress.

Top module: `gated_scaler`

## Requirements
- R1: Each of the ten channels counts rising edges of its input after a two-stage synchroniser. A pulse that is high for at least two clocks, after at least two clocks low, adds exactly one count, whatever its width.
- R2: While `run` is low, every live count and carried residue is held at zero. Counting starts from zero in the first cycle that `run` is high.
- R3: The effective period is `period_cycles` clock cycles, raised to CLK_HZ/10000 cycles (100 µs) when `period_cycles` is smaller. The first window ends on the effective-period-th rising clock edge with `run` high, and each later window is one effective period long.
- R4: At each window end, all channels are snapshotted and restarted in the same cycle. An edge detected in that cycle is counted in the new window, and windows have no gap between them.
- R5: Each held value is the largest multiple of 5 not above (carried residue + counts in the window). The remainder, 0 to 4, carries into the next window. For a steady three pulses per window, the running sum of held values is 0, 5, 5, 10, 15, 15, 20.
- R6: `irq` goes high in the cycle after a window ends and stays high until `irq_ack` is sampled high. Acknowledging clears it on the next edge.
- R7: If a window ends while `irq` is still high and `irq_ack` is not high in that cycle, `overrun` goes high. The holding registers still take the new values. `irq_ack` clears `overrun`.
- R8: A falling `cs_n` loads a 320-bit frame: channel 0 first, each channel 32 bits MSB first. `sdo` shows the current bit, and each falling `sclk` edge advances one bit. `sdo` is 0 while `cs_n` is high. Each `sclk` level must last at least three system clocks.
- R9: A serial readout in progress does not disturb counting or the snapshots of later windows.
- R10: After reset, `irq`, `overrun` and `sdo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Acquisition enable; low clears live counts |
| period_cycles | input | 32 | Requested window length in clock cycles |
| pulse_in | input | 10 | Asynchronous pulse inputs, one per channel |
| irq | output | 1 | Window-end interrupt to host |
| irq_ack | input | 1 | Host acknowledge, clears irq and overrun |
| overrun | output | 1 | A window ended before the last was acknowledged |
| sclk | input | 1 | Host serial clock, shift on falling edge |
| cs_n | input | 1 | Host chip-select, active low, frames the readout |
| sdo | output | 1 | Serial data out |

## Verification
The hardest case to reach from the ports is a pulse whose synchronised edge lands on the exact cycle the window closes. It must go to the new window, and the carried residue must survive that same boundary. The bench drives its inputs from a cycle count kept from the start of `run`. It places each pulse edge three cycles early so that the synchroniser latency lands it on a chosen edge index, and one channel is placed squarely on every boundary. Other channels run at the maximum pulse rate and at three pulses per window to exercise the quantiser. A second phase clamps a too-short period and withholds the acknowledge to force an overrun.

// File: rtl/ps_pkg.sv
package ps_pkg;

    typedef struct packed {
        logic irq;
        logic ovr;
    } ps_flags_t;

    // Shortest legal integration window, 100 microseconds, in clock cycles.
    function automatic int ps_min_cycles(input int clk_hz);
        return clk_hz / 10000;
    endfunction

endpackage

// File: rtl/ps_edge_sync.sv
module ps_edge_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);

    typedef logic [STAGES:0][W-1:0] pipe_t;
    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign lvl  = pipe_q[STAGES-1];
    assign prev = pipe_q[STAGES];

    for (genvar b = 0; b < W; b++) begin : g_chk
        // R1
        single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[b] && !prev[b]) |=> !(lvl[b] && !prev[b]));
    end

endmodule

// File: rtl/ps_period_timer.sv
module ps_period_timer #(
    parameter int PW = 32,
    parameter int MIN_CYC = 25000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period_cycles,
    output logic          tick
);

    localparam logic [PW-1:0] FLOOR = PW'(MIN_CYC);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [PW-1:0] per_eff;
    logic [PW-1:0] last_idx;

    always_comb begin
        per_eff  = (period_cycles < FLOOR) ? FLOOR : period_cycles;
        last_idx = per_eff - 1'b1;
        tick     = run && (s_q.cnt >= last_idx);
        s_d      = s_q;
        if (!run)      s_d.cnt = '0;
        else if (tick) s_d.cnt = '0;
        else           s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Checker-side count of cycles since the last window end.
    logic [PW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) since_q <= '0;
        else if (since_q != '1)     since_q <= since_q + 1'b1;
    end

    // R3
    min_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (since_q >= FLOOR - 1'b1));

endmodule

// File: rtl/ps_chan_counter.sv
module ps_chan_counter #(
    parameter int CW = 32,
    parameter int STEP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          hit,
    output logic [CW-1:0] held
);

    localparam int RW = $clog2(STEP);
    localparam int TW = CW + RW + 1;
    localparam logic [RW-1:0] LAST = RW'(STEP - 1);

    typedef struct packed {
        logic [CW-1:0] steps;
        logic [RW-1:0] res;
        logic [CW-1:0] held;
    } chan_t;

    chan_t s_d, s_q;
    logic [CW-1:0] base;

    always_comb begin
        s_d  = s_q;
        base = tick ? '0 : s_q.steps;
        if (!run) begin
            s_d.steps = '0;
            s_d.res   = '0;
        end else begin
            s_d.steps = base;
            if (hit) begin
                if (s_q.res == LAST) begin
                    s_d.res   = '0;
                    s_d.steps = base + 1'b1;
                end else begin
                    s_d.res = s_q.res + 1'b1;
                end
            end
            if (tick) s_d.held = s_q.steps * CW'(STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held = s_q.held;

    logic [TW-1:0] tot_w;
    assign tot_w = TW'(s_q.steps) * TW'(STEP) + TW'(s_q.res);

    // R1
    accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick)) |-> (tot_w == $past(tot_w) + TW'($past(hit))));

    // R4
    carry_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(tick)) |-> (tot_w == TW'($past(s_q.res)) + TW'($past(hit))));

endmodule

// File: rtl/ps_shift_out.sv
module ps_shift_out #(
    parameter int TOT = 320,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TOT-1:0] frame,
    input  logic           sclk,
    input  logic           cs_n,
    output logic           sdo
);

    typedef struct packed {
        logic [TOT-1:0] sh;
        logic           act;
    } shf_t;

    shf_t s_d, s_q;
    logic [1:0] h_lvl, h_prev;
    logic cs_fall, sclk_fall;

    ps_edge_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_host_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk}),
        .lvl  (h_lvl),
        .prev (h_prev)
    );

    assign cs_fall   = h_prev[1] && !h_lvl[1];
    assign sclk_fall = h_prev[0] && !h_lvl[0];

    always_comb begin
        s_d = s_q;
        if (h_lvl[1]) begin
            s_d.act = 1'b0;
        end else if (cs_fall) begin
            s_d.sh  = frame;
            s_d.act = 1'b1;
        end else if (s_q.act && sclk_fall) begin
            s_d.sh = {s_q.sh[TOT-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo = s_q.act & s_q.sh[TOT-1];

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_lvl[1] |=> !sdo);

    // R8
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (sdo == $past(frame[TOT-1])));

endmodule

// File: rtl/gated_scaler.sv
module gated_scaler
    import ps_pkg::*;
#(
    parameter int NCH = 10,
    parameter int CW = 32,
    parameter int PW = 32,
    parameter int CLK_HZ = 250_000_000,
    parameter int STEP = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [PW-1:0]  period_cycles,
    input  logic [NCH-1:0] pulse_in,
    output logic           irq,
    input  logic           irq_ack,
    output logic           overrun,
    input  logic           sclk,
    input  logic           cs_n,
    output logic           sdo
);

    localparam int MIN_CYC = ps_min_cycles(CLK_HZ);
    localparam int TOT = NCH * CW;

    logic [NCH-1:0] p_lvl, p_prev, p_rise;
    logic           tick;
    logic [CW-1:0]  held [NCH];
    logic [TOT-1:0] frame;
    ps_flags_t      f_d, f_q;

    ps_edge_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pulse_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pulse_in),
        .lvl  (p_lvl),
        .prev (p_prev)
    );

    assign p_rise = p_lvl & ~p_prev;

    ps_period_timer #(.PW(PW), .MIN_CYC(MIN_CYC)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .period_cycles(period_cycles),
        .tick         (tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ps_chan_counter #(.CW(CW), .STEP(STEP)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run),
            .tick (tick),
            .hit  (p_rise[c]),
            .held (held[c])
        );
        assign frame[(NCH-1-c)*CW +: CW] = held[c];
    end

    always_comb begin
        f_d = f_q;
        if (tick) begin
            f_d.irq = 1'b1;
            f_d.ovr = f_q.ovr | (f_q.irq & ~irq_ack);
        end else if (irq_ack) begin
            f_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign irq     = f_q.irq;
    assign overrun = f_q.ovr;

    ps_shift_out #(.TOT(TOT), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .frame(frame),
        .sclk (sclk),
        .cs_n (cs_n),
        .sdo  (sdo)
    );

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    // R7
    overrun_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(tick) && $past(irq)));

endmodule

// File: tb/gated_scaler_bench.sv
module gated_scaler_bench;

    localparam int NCH = 10;
    localparam int CW  = 32;
    localparam int HZ  = 4_000_000;
    localparam int TOT = NCH * CW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n, run, irq, irq_ack, overrun, sclk, cs_n, sdo;
    logic [31:0]    period_cycles;
    logic [NCH-1:0] pulse_in = '0;

    gated_scaler #(.CLK_HZ(HZ)) u_gated_scaler (
        .clk(clk), .rst_n(rst_n), .run(run), .period_cycles(period_cycles),
        .pulse_in(pulse_in), .irq(irq), .irq_ack(irq_ack), .overrun(overrun),
        .sclk(sclk), .cs_n(cs_n), .sdo(sdo)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    int per = 2600;
    int mode = 0;
    bit done = 0;
    int exp_cnt [16][NCH];
    int res [NCH];

    // An edge counted on rising edge k (k-th edge with run high) belongs to window k/per.
    function automatic bit pat(input int md, input int c, input int k, input int p);
        if (k < 6) return 1'b0;
        if (md == 0) begin
            if (c == 0) return (k % p == 100) || (k % p == 900) || (k % p == 1700);
            if (c == 1) return (k % p == 0) || (k % p == p - 4);
            return (k % (c + 2)) == 0;
        end
        return (k % 40 == 10) && ((k / 40) % 10 < c);
    endfunction

    always @(posedge clk) cyc <= run ? cyc + 1 : 0;

    // Rising input three cycles early lands the detected edge on index k.
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++)
            pulse_in[c] = pat(mode, c, cyc + 2, per) | pat(mode, c, cyc + 3, per);
    end

    always @(posedge clk) begin
        if (run) begin
            for (int c = 0; c < NCH; c++) begin
                if (pat(mode, c, cyc + 1, per) && ((cyc + 1) / per) < 16)
                    exp_cnt[(cyc + 1) / per][c]++;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic read_frame(output logic [TOT-1:0] f);
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int b = TOT - 1; b >= 0; b--) begin
            f[b] = sdo;
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
    endtask

    task automatic do_ack();
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
    endtask

    task automatic clear_expect();
        for (int p = 0; p < 16; p++)
            for (int c = 0; c < NCH; c++) exp_cnt[p][c] = 0;
        for (int c = 0; c < NCH; c++) res[c] = 0;
    endtask

    function automatic int quant(input int c, input int n);
        int acc;
        acc = res[c] + exp_cnt[n][c];
        res[c] = acc % 5;
        return acc - acc % 5;
    endfunction

    initial begin
        logic [TOT-1:0] fr;
        int seq [7] = '{0, 5, 5, 10, 15, 15, 20};
        int tot0, rep;
        run = 0; irq_ack = 0; sclk = 0; cs_n = 1; rst_n = 0;
        period_cycles = 32'd2600; per = 2600; mode = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R10 irq", irq, 0);
        chk("R10 overrun", overrun, 0);
        chk("R10 sdo", sdo, 0);

        // Phase 1: long windows, readout while counting, boundary pulses on ch1.
        clear_expect();
        tot0 = 0;
        run = 1;
        for (int n = 0; n < 7; n++) begin
            while (!irq) @(negedge clk);
            read_frame(fr);
            for (int c = 0; c < NCH; c++) begin
                rep = quant(c, n);
                chk($sformatf("R1 R4 R5 R9 win%0d ch%0d", n, c), fr[(NCH-1-c)*CW +: CW], rep);
            end
            tot0 += int'(fr[(NCH-1)*CW +: CW]);
            chk($sformatf("R5 running sum win%0d", n), tot0, seq[n]);
            chk("R7 no overrun when acked", overrun, 0);
            do_ack();
            @(negedge clk);
            chk("R6 irq cleared by ack", irq, 0);
        end
        run = 0;
        repeat (20) @(negedge clk);

        // Phase 2: clamped period, withheld ack, restart from zero.
        mode = 1; period_cycles = 32'd10; per = HZ / 10000;
        clear_expect();
        run = 1;
        while (!irq) @(negedge clk);
        chk("R3 clamped first window length", cyc, per);
        chk("R7 overrun low after first window", overrun, 0);
        while (cyc < 2 * per + 1) @(negedge clk);
        chk("R7 overrun after unacked window", overrun, 1);
        chk("R6 irq held without ack", irq, 1);
        while (cyc < 3 * per + 5) @(negedge clk);
        run = 0;
        read_frame(fr);
        for (int c = 0; c < NCH; c++) begin
            rep = quant(c, 0);
            rep = quant(c, 1);
            rep = quant(c, 2);
            chk($sformatf("R2 R7 held after overrun ch%0d", c), fr[(NCH-1-c)*CW +: CW], rep);
        end
        repeat (5) @(negedge clk);
        chk("R8 sdo low with cs_n high", sdo, 0);
        do_ack();
        @(negedge clk);
        chk("R7 overrun cleared by ack", overrun, 0);
        chk("R6 irq cleared", irq, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule